// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for one bank of interrupt sources. For each source it holds a priority, a target server number, the current level of the source line, a masked-pending flag and a resend flag. It turns source events into delivery attempts toward a presentation unit, one source at a time. The events are a rising source line, an end-of-interrupt for a source whose line is still high, a rejected source handed back by the presenter, a resend scan, and the unmasking of a source that was held pending.

Each event marks its source as wanting delivery. An arbiter serves the marked sources lowest index first. An attempt first clears the source's resend flag. A masked source is then parked as masked-pending and no request is made. Otherwise a request carrying the source number, priority and server goes out on a valid/ready handshake, and the presenter answers later with accept or fail. A failed attempt sets the source's resend flag and pulses a notice naming the target server, so that the server records this bank in its resend map. A later resend scan re-attempts every flagged source.

Top module: `intsrc_ctl`

## Requirements
- R1: After reset every source has priority all ones (masked), all flags are clear, and req_valid and rmap_valid are low. A source that rises before it is configured produces no request.
- R2: An attempt on a source whose priority is all ones sets its masked-pending flag and makes no request. Writing a priority other than all ones to a source with masked-pending set clears the flag and starts an attempt, which uses the new priority.
- R3: Every attempt clears the source's resend flag before the mask check, so a source that was later delivered is not re-attempted by a following resend scan.
- R4: A fail result sets the resend flag of the source in flight. One cycle after the result, rmap_valid is high for exactly one cycle with rmap_server equal to that source's server.
- R5: A scan_req pulse re-attempts exactly the sources whose resend flag is set, in ascending index order.
- R6: An end-of-interrupt for a source whose line is high re-attempts that source. One for a source whose line is low causes nothing.
- R7: An end-of-interrupt whose number equals IPI_NUM (default 2), or lies outside BASE..BASE+N_SRC-1, is ignored.
- R8: A rejected source number returned on rej_valid/rej_num is re-attempted exactly like a new attempt, including the mask check.
- R9: req_valid with its num, prio and server stays stable until req_ready. Only one source is in flight, and no new request appears before the result of the previous one.
- R10: A rising edge on src_level[i] starts an attempt for source i. The request carries number BASE+i together with that source's configured priority and server.
- R11: When several sources want delivery at once, the lowest index is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | N_SRC | Level of each source line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index written |
| cfg_prio | input | PRIO_W | New priority (all ones = masked) |
| cfg_server | input | SRV_W | New target server |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Source number being ended |
| rej_valid | input | 1 | Rejected-source strobe from the presenter |
| rej_num | input | NUM_W | Rejected source number |
| scan_req | input | 1 | Resend scan request |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Presenter takes the request |
| req_num | output | NUM_W | Source number of the request |
| req_prio | output | PRIO_W | Priority of the request |
| req_server | output | SRV_W | Target server of the request |
| res_valid | input | 1 | Delivery result valid |
| res_accept | input | 1 | 1 = accepted, 0 = failed |
| rmap_valid | output | 1 | Pulse: set resend-map bit at server |
| rmap_server | output | SRV_W | Server to mark |

## Verification
The properties assume that the presenter gives res_valid only after it has taken a request, and then exactly once for that request. They also assume that a configuration write never lands in the same cycle as an attempt on the same source. The bench's responder returns the result two cycles after the handshake and never otherwise. Configuration writes, ends of interrupt and rejects are issued only while the block is idle, so these assumptions hold for every stimulus.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } isc_state_e;
endpackage

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/isc_numdec.sv
module isc_numdec #(
  parameter int N          = 16,
  parameter int IDX_W      = 4,
  parameter int NUM_W      = 8,
  parameter int BASE       = 0,
  parameter int IGNORE_NUM = 2
) (
  input  logic [NUM_W-1:0] num,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + N);

  logic in_rng;
  assign in_rng = ({1'b0, num} >= LO) && ({1'b0, num} < HI);
  assign hit    = in_rng && (num != NUM_W'(IGNORE_NUM));
  assign idx    = IDX_W'(num - NUM_W'(BASE));
endmodule

// File: rtl/intsrc_ctl.sv
module intsrc_ctl
  import isc_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int NUM_W   = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int BASE    = 0,
  parameter int IPI_NUM = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           src_level,
  input  logic                       cfg_we,
  input  logic [$clog2(N_SRC)-1:0]   cfg_idx,
  input  logic [PRIO_W-1:0]          cfg_prio,
  input  logic [SRV_W-1:0]           cfg_server,
  input  logic                       eoi_valid,
  input  logic [NUM_W-1:0]           eoi_num,
  input  logic                       rej_valid,
  input  logic [NUM_W-1:0]           rej_num,
  input  logic                       scan_req,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [NUM_W-1:0]           req_num,
  output logic [PRIO_W-1:0]          req_prio,
  output logic [SRV_W-1:0]           req_server,
  input  logic                       res_valid,
  input  logic                       res_accept,
  output logic                       rmap_valid,
  output logic [SRV_W-1:0]           rmap_server
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  // per-source state
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [PRIO_W-1:0] prio_n [N_SRC];
  logic [SRV_W-1:0]  srv_q  [N_SRC];
  logic [SRV_W-1:0]  srv_n  [N_SRC];
  logic [N_SRC-1:0]  asr_q, want_q, want_n, resend_q, resend_n, mp_q, mp_n;

  isc_state_e        state_q, state_n;
  logic [IDX_W-1:0]  cur_q;
  logic [PRIO_W-1:0] cur_prio_q;
  logic [SRV_W-1:0]  cur_srv_q;

  // named events
  logic             want_any, ev_pick, pick_masked, ev_fail;
  logic [IDX_W-1:0] pick_idx;
  logic             eoi_hit, rej_hit, eoi_go, rej_go, unmask_go;
  logic [IDX_W-1:0] eoi_idx, rej_idx;
  logic [N_SRC-1:0] lvl_rise;

  isc_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .vec(want_q), .any(want_any), .idx(pick_idx)
  );

  isc_numdec #(.N(N_SRC), .IDX_W(IDX_W), .NUM_W(NUM_W), .BASE(BASE),
               .IGNORE_NUM(IPI_NUM)) u_eoi_dec (
    .num(eoi_num), .hit(eoi_hit), .idx(eoi_idx)
  );

  isc_numdec #(.N(N_SRC), .IDX_W(IDX_W), .NUM_W(NUM_W), .BASE(BASE),
               .IGNORE_NUM(IPI_NUM)) u_rej_dec (
    .num(rej_num), .hit(rej_hit), .idx(rej_idx)
  );

  assign ev_pick     = (state_q == ST_IDLE) && want_any;
  assign pick_masked = (prio_q[pick_idx] == PRIO_MASKED);
  assign ev_fail     = (state_q == ST_WAIT) && res_valid && !res_accept;
  assign lvl_rise    = src_level & ~asr_q;
  assign eoi_go      = eoi_valid && eoi_hit && asr_q[eoi_idx];
  assign rej_go      = rej_valid && rej_hit;
  assign unmask_go   = cfg_we && (cfg_prio != PRIO_MASKED) && mp_q[cfg_idx];

  // per-source next state
  always_comb begin
    want_n   = want_q;
    resend_n = resend_q;
    mp_n     = mp_q;
    prio_n   = prio_q;
    srv_n    = srv_q;
    if (ev_pick) begin
      want_n[pick_idx]   = 1'b0;
      resend_n[pick_idx] = 1'b0;
      if (pick_masked) mp_n[pick_idx] = 1'b1;
    end
    if (ev_fail)  resend_n[cur_q] = 1'b1;
    if (scan_req) want_n = want_n | resend_q;
    want_n = want_n | lvl_rise;
    if (eoi_go) want_n[eoi_idx] = 1'b1;
    if (rej_go) want_n[rej_idx] = 1'b1;
    if (cfg_we) begin
      prio_n[cfg_idx] = cfg_prio;
      srv_n[cfg_idx]  = cfg_server;
    end
    if (unmask_go) begin
      mp_n[cfg_idx]   = 1'b0;
      want_n[cfg_idx] = 1'b1;
    end
  end

  // delivery sequencer
  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: if (ev_pick && !pick_masked) state_n = ST_REQ;
      ST_REQ:  if (req_ready) state_n = ST_WAIT;
      ST_WAIT: if (res_valid) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) begin
        prio_q[i] <= PRIO_MASKED;
        srv_q[i]  <= '0;
      end
      asr_q       <= '0;
      want_q      <= '0;
      resend_q    <= '0;
      mp_q        <= '0;
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      cur_prio_q  <= '0;
      cur_srv_q   <= '0;
      rmap_valid  <= 1'b0;
      rmap_server <= '0;
    end else begin
      prio_q     <= prio_n;
      srv_q      <= srv_n;
      asr_q      <= src_level;
      want_q     <= want_n;
      resend_q   <= resend_n;
      mp_q       <= mp_n;
      state_q    <= state_n;
      rmap_valid <= ev_fail;
      if (ev_fail) rmap_server <= cur_srv_q;
      if (ev_pick) begin
        cur_q      <= pick_idx;
        cur_prio_q <= prio_q[pick_idx];
        cur_srv_q  <= srv_q[pick_idx];
      end
    end
  end

  assign req_valid  = (state_q == ST_REQ);
  assign req_num    = NUM_W'(BASE) + NUM_W'(cur_q);
  assign req_prio   = cur_prio_q;
  assign req_server = cur_srv_q;

  // ---------------- assertions ----------------
  p_masked_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pick && pick_masked |=> mp_q[cur_q] && !req_valid)
    else $error("masked attempt did not park as pending");

  p_req_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_prio != PRIO_MASKED)
    else $error("request issued with masked priority");

  p_clear_resend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pick |=> !resend_q[cur_q])
    else $error("attempt left resend flag set");

  p_fail_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> resend_q[cur_q] && rmap_valid)
    else $error("failed delivery not recorded");

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_num) &&
      $stable(req_prio) && $stable(req_server))
    else $error("request dropped or changed before ready");
endmodule

// File: tb/sim_intsrc_ctl.sv
`timescale 1ns/1ps
module sim_intsrc_ctl;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_level = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_prio = '0;
  logic [3:0] cfg_server = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_num = '0;
  logic rej_valid = 1'b0;
  logic [7:0] rej_num = '0;
  logic scan_req = 1'b0;
  logic req_valid, req_ready, res_valid, res_accept, rmap_valid;
  logic [7:0] req_num, req_prio;
  logic [3:0] req_server, rmap_server;

  always #2.5 clk = ~clk;

  intsrc_ctl u0 (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_server(cfg_server),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .rej_valid(rej_valid), .rej_num(rej_num),
    .scan_req(scan_req), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_prio(req_prio), .req_server(req_server),
    .res_valid(res_valid), .res_accept(res_accept),
    .rmap_valid(rmap_valid), .rmap_server(rmap_server)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // ---------------- reference model ----------------
  int m_prio [N];
  int m_srv  [N];
  logic [N-1:0] m_want, m_rs, m_mp, m_asr;
  int m_st, m_cur, m_curp, m_curs, m_rmv, m_rms;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_prio[i] = 255; m_srv[i] = 0; end
      m_want = '0; m_rs = '0; m_mp = '0; m_asr = '0;
      m_st = 0; m_cur = 0; m_curp = 0; m_curs = 0; m_rmv = 0; m_rms = 0;
    end else begin
      logic [N-1:0] rs_o, mp_o, asr_o;
      int p;
      rs_o = m_rs; mp_o = m_mp; asr_o = m_asr;
      p = -1;
      for (int i = N - 1; i >= 0; i--) if (m_want[i]) p = i;
      m_rmv = 0;
      if (m_st == 0) begin
        if (p >= 0) begin
          m_want[p] = 1'b0; m_rs[p] = 1'b0;
          m_cur = p; m_curp = m_prio[p]; m_curs = m_srv[p];
          if (m_prio[p] == 255) m_mp[p] = 1'b1; else m_st = 1;
        end
      end else if (m_st == 1) begin
        if (req_ready) m_st = 2;
      end else begin
        if (res_valid) begin
          m_st = 0;
          if (!res_accept) begin m_rs[m_cur] = 1'b1; m_rmv = 1; m_rms = m_curs; end
        end
      end
      if (scan_req) m_want = m_want | rs_o;
      m_want = m_want | (src_level & ~asr_o);
      if (eoi_valid && eoi_num < N && eoi_num != 2 && asr_o[eoi_num[3:0]])
        m_want[eoi_num[3:0]] = 1'b1;
      if (rej_valid && rej_num < N && rej_num != 2) m_want[rej_num[3:0]] = 1'b1;
      if (cfg_we) begin
        m_prio[cfg_idx] = int'(cfg_prio);
        m_srv[cfg_idx]  = int'(cfg_server);
        if (cfg_prio != 8'hFF && mp_o[cfg_idx]) begin
          m_mp[cfg_idx] = 1'b0; m_want[cfg_idx] = 1'b1;
        end
      end
      m_asr = src_level;
    end
  end

  task automatic chk(string r, string what, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(tag, "req_valid", int'(req_valid), int'(m_st == 1));
      if (m_st == 1) begin
        chk(tag, "req_num", int'(req_num), m_cur);
        chk(tag, "req_prio", int'(req_prio), m_curp);
        chk(tag, "req_server", int'(req_server), m_curs);
      end
      chk(tag, "rmap_valid", int'(rmap_valid), m_rmv);
      if (m_rmv != 0) chk(tag, "rmap_server", int'(rmap_server), m_rms);
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- presenter responder ----------------
  int q_log [$];
  logic [N-1:0] fail_mask = '0;
  int rdy_dly = 0;
  int rdy_cnt = 0;
  int res_cnt = 0;
  bit waiting = 0;
  int rmap_cnt = 0;
  int rmap_last = -1;
  int held_num = 0;

  initial begin req_ready = 1'b0; res_valid = 1'b0; res_accept = 1'b0; end

  always @(negedge clk) begin
    req_ready = 1'b0; res_valid = 1'b0;
    if (rmap_valid) begin rmap_cnt++; rmap_last = int'(rmap_server); end
    if (waiting) begin
      if (res_cnt == 0) begin
        res_valid = 1'b1; res_accept = !fail_mask[held_num]; waiting = 0;
      end else res_cnt--;
    end else if (req_valid) begin
      if (rdy_cnt >= rdy_dly) begin
        req_ready = 1'b1; waiting = 1; res_cnt = 1; rdy_cnt = 0;
        held_num = int'(req_num); q_log.push_back(int'(req_num));
      end else rdy_cnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int idx, int pr, int sv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_prio = 8'(pr); cfg_server = 4'(sv);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic eoi(int num);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = 8'(num);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic rej(int num);
    @(negedge clk); rej_valid = 1'b1; rej_num = 8'(num);
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic scan();
    @(negedge clk); scan_req = 1'b1;
    @(negedge clk); scan_req = 1'b0;
  endtask

  function automatic int lg(int k);
    return (k < q_log.size()) ? q_log[k] : -1;
  endfunction

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state; an unconfigured source stays silent
    tag = "R1";
    chk("R1", "req_valid after reset", int'(req_valid), 0);
    chk("R1", "rmap_valid after reset", int'(rmap_valid), 0);
    src_level[3] = 1'b1;
    idle(10);
    chk("R1", "requests from masked source", q_log.size(), 0);

    // R2: unmasking a pending source starts an attempt
    tag = "R2";
    cfg(3, 5, 2);
    idle(10);
    chk("R2", "unmask delivery count", q_log.size(), 1);
    chk("R2", "unmask delivery num", lg(0), 3);
    q_log.delete();

    // R10 / R11: configuration and simultaneous rises
    tag = "R11";
    cfg(1, 4, 1); cfg(4, 6, 3); cfg(2, 3, 0); cfg(5, 8, 4); cfg(0, 1, 7);
    for (int i = 6; i <= 12; i++) cfg(i, 7, 5);
    @(negedge clk); src_level[1] = 1'b1; src_level[4] = 1'b1;
    idle(20);
    chk("R11", "count", q_log.size(), 2);
    chk("R11", "first served", lg(0), 1);
    chk("R10", "second served", lg(1), 4);
    q_log.delete();

    // R4: failed delivery marks resend map
    tag = "R4";
    fail_mask[6] = 1'b1;
    @(negedge clk); src_level[6] = 1'b1;
    idle(12);
    chk("R4", "attempt num", lg(0), 6);
    chk("R4", "rmap pulses", rmap_cnt, 1);
    chk("R4", "rmap server", rmap_last, 5);

    // R5: scan walks flagged sources ascending
    tag = "R5";
    fail_mask[7] = 1'b1; fail_mask[9] = 1'b1; fail_mask[12] = 1'b1;
    @(negedge clk); src_level[12] = 1'b1; idle(10);
    @(negedge clk); src_level[9] = 1'b1;  idle(10);
    @(negedge clk); src_level[7] = 1'b1;  idle(10);
    chk("R5", "rmap pulses after fails", rmap_cnt, 4);
    fail_mask = '0;
    q_log.delete();
    scan();
    idle(30);
    chk("R5", "scan count", q_log.size(), 4);
    chk("R5", "scan order 0", lg(0), 6);
    chk("R5", "scan order 1", lg(1), 7);
    chk("R5", "scan order 2", lg(2), 9);
    chk("R5", "scan order 3", lg(3), 12);
    q_log.delete();

    // R3 / R8: reject redelivers and clears the resend flag
    tag = "R3";
    fail_mask[10] = 1'b1;
    @(negedge clk); src_level[10] = 1'b1;
    idle(10);
    fail_mask = '0;
    q_log.delete();
    rej(10);
    idle(10);
    chk("R8", "reject redelivery", lg(0), 10);
    q_log.delete();
    scan();
    idle(15);
    chk("R3", "scan after redelivery", q_log.size(), 0);

    // R6: end-of-interrupt with line high / low
    tag = "R6";
    eoi(4);
    idle(10);
    chk("R6", "eoi asserted redelivers", lg(0), 4);
    q_log.delete();
    @(negedge clk); src_level[1] = 1'b0;
    idle(2);
    eoi(1);
    idle(10);
    chk("R6", "eoi deasserted", q_log.size(), 0);

    // R7: reserved and out-of-bank numbers
    tag = "R7";
    @(negedge clk); src_level[2] = 1'b1;
    idle(10);
    chk("R7", "source 2 delivered on rise", lg(0), 2);
    q_log.delete();
    eoi(2);
    eoi(200);
    eoi(16);
    idle(10);
    chk("R7", "ignored eoi", q_log.size(), 0);

    // R8 / R2: reject of a masked source parks it
    tag = "R8";
    rej(5);
    idle(10);
    chk("R8", "reject unmasked", lg(0), 5);
    q_log.delete();
    cfg(5, 255, 4);
    rej(5);
    idle(10);
    chk("R8", "reject masked no request", q_log.size(), 0);
    cfg(5, 9, 4);
    idle(10);
    chk("R2", "unmask after masked reject", lg(0), 5);
    q_log.delete();

    // R9: slow ready, request held
    tag = "R9";
    rdy_dly = 3;
    @(negedge clk); src_level[0] = 1'b1; src_level[11] = 1'b1;
    idle(25);
    chk("R9", "held request count", q_log.size(), 2);
    chk("R9", "held request 0", lg(0), 0);
    chk("R9", "held request 1", lg(1), 11);

    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule